// File: doc/BRIEF.md
# Timed Voltage-Frequency Transition Controller

This block moves a core from one supply-voltage code and clock divisor to another while the core is held idle. Firmware running with management privilege first stages a target voltage ID and a target divisor in a control register. It then writes a non-zero length to a stall timer. That write is the only trigger. It raises a stop request towards the clock controller and places the staged values on the live voltage-ID and divisor outputs. The timer then counts down once per bus clock.

When the timer runs out, the stop request drops and a one-cycle completion pulse is raised. The live outputs keep the new settings until the next transition starts. A timer write of zero does nothing, and a timer write during a transition is ignored. Writes without privilege have no effect of any kind.

The sequencer has three states. `ST_IDLE` waits for a start. `ST_HOLD` stalls the core and counts down. `ST_DONE` lasts one cycle and signals completion. The transitions are:
- IDLE→HOLD on an accepted start.
- HOLD→DONE on timer expiry.
- DONE→HOLD on an accepted start.
- DONE→IDLE otherwise.

Top module: `vf_transition_ctrl`

## Requirements
- R1: After reset, `stop_req`, `busy` and `done` are low, and `vid_out`/`div_out` hold the parameters `VID_DEF`/`DIV_DEF` (defaults 5'h0C and 3'd2).
- R2: A privileged write with `wr_sel`=0 stages the voltage ID from `wr_data[VID_W-1:0]` and the divisor from `wr_data[VID_W+DIV_W-1:VID_W]`. It does not change `vid_out` or `div_out`.
- R3: A privileged write with `wr_sel`=1 and a non-zero `wr_data[CNT_W-1:0]`, made while not busy, has an effect from the next cycle on. `stop_req` and `busy` go high, and `vid_out`/`div_out` take the staged values.
- R4: For a start count of N, `stop_req` stays high for exactly N clock cycles.
- R5: In the cycle after `stop_req` falls, `done` is high for exactly one cycle and `busy` is low.
- R6: A privileged timer write of zero starts nothing: `stop_req` stays low and the outputs are unchanged.
- R7: While busy, timer writes do not change the stall length. Staging writes do not change the live outputs.
- R8: Writes with `wr_priv` low change neither the staged fields nor the timer, and start nothing.
- R9: After a transition, `vid_out`/`div_out` keep the applied values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_priv | input | 1 | Write comes from the privileged management path |
| wr_sel | input | 1 | 0 = staging register, 1 = stall timer |
| wr_data | input | DATA_W | Write data |
| vid_out | output | VID_W | Live voltage ID code |
| div_out | output | DIV_W | Live clock divisor |
| stop_req | output | 1 | Stop request to the clock controller |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `wr_en`, `wr_priv`, `wr_sel` and `wr_data` are synchronous to `clk` and carry no unknowns after reset. They also assume that at most one write arrives per cycle. The bench meets this by changing inputs only on the falling edge and by holding each write for exactly one cycle. It lowers `wr_en` between operations. Privileged and unprivileged writes, zero and non-zero counts, and writes during a stall are all driven through that same single-write path.

// File: rtl/vf_pkg.sv
package vf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_DONE = 2'd2
    } vf_state_e;
endpackage

// File: rtl/vf_stage_regs.sv
module vf_stage_regs #(
    parameter int VID_W = 5,
    parameter int DIV_W = 3,
    parameter int CNT_W = 16,
    parameter int DATA_W = 16,
    parameter logic [VID_W-1:0] VID_DEF = '0,
    parameter logic [DIV_W-1:0] DIV_DEF = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [VID_W-1:0]  stg_vid,
    output logic [DIV_W-1:0]  stg_div,
    output logic              start_req,
    output logic [CNT_W-1:0]  cnt_val
);
    localparam int DIV_LO = VID_W;
    localparam int DIV_HI = VID_W + DIV_W - 1;

    logic wr_ok;

    assign wr_ok     = wr_en && wr_priv;
    assign cnt_val   = wr_data[CNT_W-1:0];
    assign start_req = wr_ok && wr_sel && (cnt_val != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vid <= VID_DEF;
            stg_div <= DIV_DEF;
        end else if (wr_ok && !wr_sel) begin
            stg_vid <= wr_data[VID_W-1:0];
            stg_div <= wr_data[DIV_HI:DIV_LO];
        end
    end

    // R8: unprivileged writes leave the staged fields alone
    p_unpriv_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> ($stable(stg_vid) && $stable(stg_div)));
endmodule

// File: rtl/vf_stall_timer.sv
module vf_stall_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = run && (cnt == {{(CNT_W-1){1'b0}}, 1'b1});

    // R4: one step down per cycle while stalling
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt > 1) |=> (cnt == $past(cnt) - 1'b1));
    // R4: expiry empties the timer
    p_expire_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> (cnt == '0));
endmodule

// File: rtl/vf_seq_fsm.sv
module vf_seq_fsm
    import vf_pkg::*;
#(
    parameter int VID_W = 5,
    parameter int DIV_W = 3,
    parameter logic [VID_W-1:0] VID_DEF = '0,
    parameter logic [DIV_W-1:0] DIV_DEF = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             expire,
    input  logic [VID_W-1:0] stg_vid,
    input  logic [DIV_W-1:0] stg_div,
    output logic             accept,
    output logic             run,
    output logic [VID_W-1:0] vid_out,
    output logic [DIV_W-1:0] div_out,
    output logic             stop_req,
    output logic             busy,
    output logic             done
);
    vf_state_e state, state_n;

    assign accept = start_req && (state != ST_HOLD);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (accept) state_n = ST_HOLD;
            ST_HOLD: if (expire) state_n = ST_DONE;
            ST_DONE: state_n = accept ? ST_HOLD : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_out <= VID_DEF;
            div_out <= DIV_DEF;
        end else if (accept) begin
            vid_out <= stg_vid;
            div_out <= stg_div;
        end
    end

    always_comb begin
        run      = (state == ST_HOLD);
        stop_req = run;
        busy     = run;
        done     = (state == ST_DONE);
    end

    // R3: an accepted start enters the stall
    p_enter_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_HOLD));
    // R7/R9: live settings move only on an accepted start
    p_live_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(vid_out) && $stable(div_out)));
    // R5: completion lasts one cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: expiry leads to completion
    p_expire_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (done && !busy));
endmodule

// File: rtl/vf_transition_ctrl.sv
module vf_transition_ctrl #(
    parameter int VID_W = 5,
    parameter int DIV_W = 3,
    parameter int CNT_W = 16,
    parameter int DATA_W = 16,
    parameter logic [VID_W-1:0] VID_DEF = 5'h0C,
    parameter logic [DIV_W-1:0] DIV_DEF = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [VID_W-1:0]  vid_out,
    output logic [DIV_W-1:0]  div_out,
    output logic              stop_req,
    output logic              busy,
    output logic              done
);
    logic [VID_W-1:0] stg_vid;
    logic [DIV_W-1:0] stg_div;
    logic             start_req;
    logic [CNT_W-1:0] cnt_val;
    logic             accept;
    logic             run;
    logic             expire;

    vf_stage_regs #(
        .VID_W(VID_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
        .VID_DEF(VID_DEF), .DIV_DEF(DIV_DEF)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv),
        .wr_sel(wr_sel), .wr_data(wr_data), .stg_vid(stg_vid),
        .stg_div(stg_div), .start_req(start_req), .cnt_val(cnt_val)
    );

    vf_stall_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cnt_val),
        .run(run), .expire(expire)
    );

    vf_seq_fsm #(
        .VID_W(VID_W), .DIV_W(DIV_W), .VID_DEF(VID_DEF), .DIV_DEF(DIV_DEF)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .expire(expire),
        .stg_vid(stg_vid), .stg_div(stg_div), .accept(accept), .run(run),
        .vid_out(vid_out), .div_out(div_out), .stop_req(stop_req),
        .busy(busy), .done(done)
    );

    // R6: a zero count while idle leaves the core running
    p_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_priv && wr_sel && wr_data[CNT_W-1:0] == '0 && !busy)
        |=> !stop_req);
    // R8: unprivileged writes never stall the core
    p_unpriv_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv && !busy) |=> !stop_req);
endmodule

// File: tb/vf_transition_ctrl_bench.sv
module vf_transition_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_priv = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [4:0]  vid_out;
    logic [2:0]  div_out;
    logic        stop_req, busy, done;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    vf_transition_ctrl u_vf_transition_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv),
        .wr_sel(wr_sel), .wr_data(wr_data), .vid_out(vid_out),
        .div_out(div_out), .stop_req(stop_req), .busy(busy), .done(done)
    );

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one write, held one cycle; entered and left at a falling edge
    task automatic wr(input logic sel, input logic [15:0] d, input logic priv);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_priv = priv;
        @(negedge clk);
        wr_en = 1'b0; wr_priv = 1'b0;
    endtask

    function automatic logic [15:0] stage_word(input logic [4:0] v, input logic [2:0] dv);
        return {8'h00, dv, v};
    endfunction

    task automatic count_hold(output int n);
        n = 0;
        while (stop_req && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1", "stop_req", stop_req, 0);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "vid_out", vid_out, 5'h0C);
        check("R1", "div_out", div_out, 3'd2);
    endtask

    task automatic t_stage_only();
        wr(1'b0, stage_word(5'h15, 3'd5), 1'b1);
        @(negedge clk);
        check("R2", "vid_out unchanged", vid_out, 5'h0C);
        check("R2", "div_out unchanged", div_out, 3'd2);
        check("R2", "no stall", stop_req, 0);
    endtask

    task automatic t_run(input int n_cyc, input int ev, input int ed);
        int n;
        wr(1'b1, 16'(n_cyc), 1'b1);
        check("R3", "stop_req raised", stop_req, 1);
        check("R3", "busy raised", busy, 1);
        check("R3", "vid_out applied", vid_out, ev);
        check("R3", "div_out applied", div_out, ed);
        count_hold(n);
        check("R4", "stall length", n, n_cyc);
        check("R5", "done pulse", done, 1);
        check("R5", "busy low at done", busy, 0);
        @(negedge clk);
        check("R5", "done single", done, 0);
    endtask

    task automatic t_zero();
        wr(1'b1, 16'h0000, 1'b1);
        check("R6", "no stall on zero", stop_req, 0);
        check("R6", "vid kept", vid_out, 5'h15);
        @(negedge clk);
        check("R6", "still idle", busy, 0);
    endtask

    task automatic t_write_during_hold();
        int n;
        wr(1'b0, stage_word(5'h07, 3'd1), 1'b1);
        wr(1'b1, 16'd6, 1'b1);
        wr(1'b1, 16'd50, 1'b1);
        wr(1'b0, stage_word(5'h1F, 3'd7), 1'b1);
        check("R7", "vid not moved by staging", vid_out, 5'h07);
        check("R7", "div not moved by staging", div_out, 3'd1);
        count_hold(n);
        check("R7", "stall length unchanged", n + 2, 6);
        @(negedge clk);
        check("R9", "vid retained", vid_out, 5'h07);
        check("R9", "div retained", div_out, 3'd1);
        repeat (3) @(negedge clk);
        check("R9", "vid still retained", vid_out, 5'h07);
    endtask

    task automatic t_unpriv();
        int n;
        wr(1'b0, stage_word(5'h03, 3'd3), 1'b0);
        wr(1'b1, 16'd9, 1'b0);
        check("R8", "no stall unpriv", stop_req, 0);
        @(negedge clk);
        check("R8", "no stall later", busy, 0);
        // staged values are still the last privileged ones (1F/7)
        wr(1'b1, 16'd2, 1'b1);
        check("R8", "staged vid untouched", vid_out, 5'h1F);
        check("R8", "staged div untouched", div_out, 3'd7);
        count_hold(n);
        check("R4", "short stall", n, 2);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage_only();
        t_run(4, 5'h15, 3'd5);
        t_run(1, 5'h15, 3'd5);
        t_zero();
        t_write_during_hold();
        t_unpriv();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule